// File: doc/BRIEF.md
# Parallel additive bit whitener

This block whitens a serial bit stream on the transmit side of an OFDM link, and removes that whitening on the receive side. A 7-bit linear feedback shift register produces a pseudo-random bit sequence. Each data bit is XORed with the next bit of that sequence. Because the operation is an XOR with a sequence that does not depend on the data, running the same circuit twice from the same start state returns the original bits. The one design therefore serves as both scrambler and descrambler.

Data arrives eight bits per beat on a valid/ready interface. Bit 0 of a byte is the earliest bit in time. The register update is unrolled eight times, so a whole byte is handled in one clock. The register state carries over from one beat to the next. At the start of each frame, a load strobe presets the register with the seed given by a parameter, which defaults to all ones. The output is registered one cycle behind the accepted input. Back-pressure from the consumer holds both the output and the register state.

Top module: `bit_whitener`

## Requirements
- R1: After reset, `outValid` is 0 and `inReady` is 1, and the register holds the seed.
- R2: Each bit step works in this order: the feedback bit is state[3] XOR state[0]; state[6:1] move into state[5:0]; the feedback bit enters state[6]; the output bit is the input bit XOR the feedback bit. Within a byte, the steps run from bit 0 to bit 7. With the all-ones seed and an input byte of 0x00, the first output byte is 0x70.
- R3: The register state carries from one accepted beat to the next, so consecutive bytes continue one unbroken sequence.
- R4: `loadSeed` presets the register with the seed. A beat accepted in the same cycle is processed from the seed. A load with no beat produces no output.
- R5: A beat is accepted when `inValid` and `inReady` are both high. Its result appears on `outData` with `outValid` high on the next cycle.
- R6: While `outValid` is high and `outReady` is low, the following hold: `outData` stays stable, `outValid` stays high, `inReady` is low, and no beat is accepted, so the state does not advance.
- R7: If a frame is reloaded with the same seed and its scrambled output is fed back in, the result is the original bytes.
- R8: When the held output is taken and no new beat is accepted in that cycle, `outValid` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadSeed | input | 1 | Preset the register with the seed |
| inValid | input | 1 | Input byte present |
| inData | input | 8 | Input byte, bit 0 earliest |
| inReady | output | 1 | Block can take an input byte |
| outValid | output | 1 | Output byte present |
| outData | output | 8 | Whitened byte |
| outReady | input | 1 | Consumer takes the output byte |

## Verification
The assertions assume that the consumer honours the valid/ready rule: it drives `outReady` independently of `outData`, and it treats a byte as taken only in a cycle where `outValid` and `outReady` are both high. The stimulus changes inputs only at the falling edge, and it drives `outReady` and `inValid` from independent random draws. This covers every mix of stall and flow, including stalls that last many cycles. Seed loads are issued both alone and together with data beats. They land at arbitrary points in a stream, so the same-cycle rule of R4 is exercised repeatedly.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int STATE_W = 7;
  localparam int BEAT_W  = 8;
  // Feedback taps of the sequence generator; fixed by the whitening polynomial.
  localparam int TAP_LO  = 0;
  localparam int TAP_HI  = 3;

  typedef struct packed {
    logic take;  // accept an input beat this cycle
    logic load;  // preset state with the seed this cycle
    logic drop;  // held output is taken and nothing replaces it
  } bwStrobes_t;
endpackage

// File: rtl/bw_ctrl.sv
module bw_ctrl
  import bw_pkg::*;
(
  input  logic       loadSeed,
  input  logic       inValid,
  input  logic       outValid,
  input  logic       outReady,
  output logic       inReady,
  output bwStrobes_t strobes
);
  logic slotFree;

  // The single output slot is free when empty or being emptied now.
  always_comb begin
    slotFree     = !outValid || outReady;
    inReady      = slotFree;
    strobes.take = inValid && slotFree;
    strobes.load = loadSeed;
    strobes.drop = outValid && outReady && !(inValid && slotFree);
  end
endmodule

// File: rtl/bw_datapath.sv
module bw_datapath
  import bw_pkg::*;
#(
  parameter logic [STATE_W-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bwStrobes_t        strobes,
  input  logic [BEAT_W-1:0] inData,
  output logic              outValid,
  output logic [BEAT_W-1:0] outData
);
  logic [STATE_W-1:0] stateQ;
  logic [STATE_W-1:0] chain [0:BEAT_W];
  logic [BEAT_W-1:0]  fbBits;
  logic [BEAT_W-1:0]  mixed;

  // A seed load in the same cycle as a beat starts that beat from the seed.
  assign chain[0] = strobes.load ? SEED : stateQ;

  for (genvar k = 0; k < BEAT_W; k++) begin : g_step
    assign fbBits[k]   = chain[k][TAP_HI] ^ chain[k][TAP_LO];
    assign chain[k+1]  = {fbBits[k], chain[k][STATE_W-1:1]};
    assign mixed[k]    = inData[k] ^ fbBits[k];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= SEED;
      outValid <= 1'b0;
      outData  <= '0;
    end else if (strobes.take) begin
      stateQ   <= chain[BEAT_W];
      outData  <= mixed;
      outValid <= 1'b1;
    end else begin
      if (strobes.load) stateQ <= SEED;
      if (strobes.drop) outValid <= 1'b0;
    end
  end
endmodule

// File: rtl/bit_whitener.sv
module bit_whitener
  import bw_pkg::*;
#(
  parameter logic [STATE_W-1:0] SEED = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadSeed,
  input  logic              inValid,
  input  logic [BEAT_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [BEAT_W-1:0] outData,
  input  logic              outReady
);
  bwStrobes_t strobes;

  bw_ctrl u_ctrl (
    .loadSeed(loadSeed),
    .inValid (inValid),
    .outValid(outValid),
    .outReady(outReady),
    .inReady (inReady),
    .strobes (strobes)
  );

  bw_datapath #(.SEED(SEED)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .inData  (inData),
    .outValid(outValid),
    .outData (outData)
  );
endmodule

// File: rtl/bw_checker.sv
module bw_checker
  import bw_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              inReady,
  input logic              outValid,
  input logic [BEAT_W-1:0] outData,
  input logic              outReady
);
  assert_accept_latency_R5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_stall_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !inReady);

  assert_drain_empty_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !inValid) |=> !outValid);
endmodule

bind bit_whitener bw_checker u_bw_checker (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .outValid(outValid),
  .outData (outData),
  .outReady(outReady)
);

// File: tb/test_bit_whitener.sv
module test_bit_whitener;
  localparam logic [6:0] SEED = 7'h7F;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       loadSeed = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inReady;
  logic       outValid;
  logic [7:0] outData;
  logic       outReady = 1'b1;

  always #2 clk = ~clk;

  bit_whitener #(.SEED(SEED)) i_bit_whitener (
    .clk(clk), .rstN(rstN), .loadSeed(loadSeed), .inValid(inValid),
    .inData(inData), .inReady(inReady), .outValid(outValid),
    .outData(outData), .outReady(outReady)
  );

  int vectors = 0;
  int errors  = 0;

  logic [6:0] model;
  logic [7:0] expData;
  logic       haveExp = 0;
  logic       pendValid = 0;
  logic       stallPrev = 0;
  logic [7:0] stallData;
  logic [7:0] lastTaken;
  logic       capOn = 0;
  int         capN = 0;
  logic [7:0] capBuf [0:15];

  // Per-bit rule from R2, bit 0 first.
  function automatic logic [14:0] scr(input logic [6:0] s, input logic [7:0] d);
    logic [7:0] o;
    logic fb;
    for (int k = 0; k < 8; k++) begin
      fb   = s[3] ^ s[0];
      s    = {fb, s[6:1]};
      o[k] = d[k] ^ fb;
    end
    return {o, s};
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [7:0] d, input logic ld, input logic rdy);
    logic [14:0] r;
    @(negedge clk);
    if (stallPrev) begin
      check(outValid === 1'b1, "R6 valid held", outValid, 1);
      check(outData === stallData, "R6 data held", outData, stallData);
    end
    if (pendValid) check(outValid === 1'b1, "R5 latency", outValid, 1);
    else if (!stallPrev) check(outValid === 1'b0, "R8 R4 no spurious output", outValid, 0);
    pendValid = 0;
    inValid = v; inData = d; loadSeed = ld; outReady = rdy;
    #1;
    if (outValid && rdy) begin
      check(haveExp && outData === expData, "R2 R3 data", outData, expData);
      lastTaken = outData;
      haveExp = 0;
      if (capOn) begin capBuf[capN] = outData; capN++; end
    end
    if (outValid && !rdy) check(inReady === 1'b0, "R6 ready low", inReady, 0);
    stallPrev = outValid && !rdy;
    stallData = outData;
    if (ld) model = SEED;
    if (v && inReady) begin
      r = scr(model, d);
      expData = r[14:7];
      model = r[6:0];
      haveExp = 1;
      pendValid = 1;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [7:0] orig [0:15];
    void'($urandom(32'd4242));
    model = SEED;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid === 1'b0, "R1 outValid", outValid, 0);
    check(inReady === 1'b1, "R1 inReady", inReady, 1);

    // R2: from reset seed, zero byte gives 0x70
    drive(1, 8'h00, 0, 1);
    drive(1, 8'h00, 0, 1);
    check(lastTaken === 8'h70, "R2 first byte", lastTaken, 8'h70);
    // R3: next byte continues the sequence (checked against model at pop)
    drive(0, 8'h00, 0, 1);
    // R4: load with a beat mid-stream restarts from seed
    drive(1, 8'h00, 1, 1);
    drive(0, 8'h00, 0, 1);
    check(lastTaken === 8'h70, "R4 same-cycle load", lastTaken, 8'h70);
    // R4: load alone, then a beat
    drive(0, 8'h00, 1, 1);
    drive(1, 8'h00, 0, 1);
    drive(0, 8'h00, 0, 1);
    check(lastTaken === 8'h70, "R4 load alone", lastTaken, 8'h70);

    // R6: long stall with a waiting beat
    drive(1, 8'hA5, 0, 0);
    repeat (5) drive(1, 8'h3C, 0, 0);
    drive(0, 8'h00, 0, 1);
    drive(0, 8'h00, 0, 1);

    // R7: scramble a frame, then descramble it
    capOn = 1; capN = 0;
    for (int i = 0; i < 16; i++) begin
      orig[i] = 8'($urandom);
      drive(1, orig[i], i == 0, 1);
    end
    drive(0, 8'h00, 0, 1);
    drive(0, 8'h00, 0, 1);
    capOn = 0;
    for (int i = 0; i < 16; i++) capBuf[i] = capBuf[i];
    begin
      logic [7:0] scrFrame [0:15];
      for (int i = 0; i < 16; i++) scrFrame[i] = capBuf[i];
      capOn = 1; capN = 0;
      for (int i = 0; i < 16; i++) drive(1, scrFrame[i], i == 0, 1);
      drive(0, 8'h00, 0, 1);
      drive(0, 8'h00, 0, 1);
      capOn = 0;
      for (int i = 0; i < 16; i++)
        check(capBuf[i] === orig[i], "R7 self-inverse", capBuf[i], orig[i]);
    end

    // Random traffic covering R3 R4 R5 R6 R8
    for (int n = 0; n < 3000; n++)
      drive(($urandom % 4) != 0, 8'($urandom), ($urandom % 50) == 0, ($urandom % 3) != 0);
    drive(0, 8'h00, 0, 1);
    drive(0, 8'h00, 0, 1);
    check(!haveExp, "R5 all beats delivered", haveExp, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule